// File: doc/BRIEF.md
# Polyphase Horizontal Line Scaler

This block changes the width of one line of 8-bit samples from a single colour plane (luma or one chroma plane). Each output sample sits at a fractional position in the input line. A 5-tap FIR filter, with one of 32 coefficient sets picked by that fraction, forms the output value. The filter window slides along the line under control of a phase accumulator. The accumulator holds the input distance between neighbouring outputs as an unsigned 16.16 fixed-point step, so ratios from ten-fold enlargement (step 0x1999) down to one-fifth reduction (step 0x50000) come from the same datapath.

Samples enter on a valid/ready stream and scaled samples leave on another. When enlarging, the input stalls while several outputs are taken from one window position. When reducing, the window moves several samples between outputs. Before a line starts, the configuration inputs give the step, the input length and the output length, and a start pulse latches them. All 160 coefficients can be written through a small write port. A level flag reports that the line has finished.

Top module: `hscale_top`

## Requirements
- R1: During reset and in the cycle after it, `out_valid`, `in_ready` and `line_done` are low. Reset loads every phase with a pass-through set: tap 2 is 256 and the other taps are 0.
- R2: Output sample k (counting from 0) is centred on input index i = floor(k*step / 65536). Its phase is bits 15:11 of the low 16 bits of k*step. The integer part of k*step must fit in 16 bits.
- R3: Tap t (0..4) multiplies the input sample at index i-2+t. The index is clamped to 0..in_len-1, so the first and last samples of the line are repeated beyond its ends. A line holds at least one input sample.
- R4: The output is (sum of coef*pixel + 128) shifted right arithmetically by 8, then clamped to 0..255. Coefficients are signed 10-bit values, and 256 stands for a gain of one.
- R5: A write with `coef_we` high stores `coef_data` at phase `coef_addr[7:3]`, tap `coef_addr[2:0]`. It takes effect for outputs issued after that clock edge. Writes with a tap field of 5, 6 or 7 change no coefficient.
- R6: In each line, exactly in_len input samples are accepted and exactly out_len outputs are produced. Input samples left over after the last output are still consumed.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: `line_done` rises once the last output has been taken and the last input consumed. While it is high, `in_ready` and `out_valid` are low. A `line_start` pulse clears it and starts the next line. A `line_start` pulse during a line is ignored.
- R9: The step ends of the range, 0x1999 (ten-fold enlargement) and 0x50000 (one-fifth reduction), give outputs that follow R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_step | input | 32 | Input distance per output, 16.16 unsigned |
| cfg_in_len | input | 16 | Input samples in the line |
| cfg_out_len | input | 16 | Output samples in the line |
| line_start | input | 1 | Pulse that latches the configuration and starts a line |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 8 | Coefficient address: phase in bits 7:3, tap in bits 2:0 |
| coef_data | input | 10 | Signed coefficient value |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | 8 | Scaled output sample |
| line_done | output | 1 | Line finished; held until the next start |

## Verification
The assertions assume that a line starts only from idle. They also assume that the input length is at least one and that out_len times the step keeps its integer part within 16 bits. If that integer part overflowed, the window centre could no longer keep pace with the target position. The stimulus keeps every line within these bounds, with at most 60 outputs and steps of at most 0x50000. Coefficient writes happen only while no line is running. A start pulse in the middle of a line is used deliberately, to show that it is ignored.

// File: rtl/hscale_pkg.sv
package hscale_pkg;

    localparam int PIX_W    = 8;
    localparam int COEF_W   = 10;
    localparam int TAPS     = 5;
    localparam int PHASES   = 32;
    localparam int PHASE_W  = $clog2(PHASES);
    localparam int TAP_AW   = 3;
    localparam int LEN_W    = 16;
    localparam int FRAC_W   = 16;
    localparam int ACC_W    = LEN_W + FRAC_W;
    localparam int SUM_W    = COEF_W + PIX_W + 4;
    localparam int NORM_SH  = 8;

    typedef logic [PIX_W-1:0]                  pix_t;
    typedef logic [TAPS-1:0][PIX_W-1:0]        win_t;
    typedef logic [TAPS-1:0][COEF_W-1:0]       coefs_t;

    typedef enum logic {ST_IDLE, ST_RUN} state_t;

    typedef struct packed {
        logic [ACC_W-1:0] step;
        logic [LEN_W-1:0] in_len;
        logic [LEN_W-1:0] out_len;
    } cfg_t;

    function automatic pix_t round_clamp(input logic signed [SUM_W-1:0] s);
        logic signed [SUM_W-1:0] r;
        r = (s + SUM_W'(1 << (NORM_SH - 1))) >>> NORM_SH;
        if (r < 0)
            return '0;
        else if (r > SUM_W'((1 << PIX_W) - 1))
            return '1;
        else
            return r[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/hscale_coef_bank.sv
module hscale_coef_bank
    import hscale_pkg::*;
#(
    parameter int NPH   = PHASES,
    parameter int NTAP  = TAPS,
    parameter int CW    = COEF_W,
    localparam int PW   = $clog2(NPH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [PW-1:0]             wr_phase,
    input  logic [TAP_AW-1:0]         wr_tap,
    input  logic [CW-1:0]             wr_data,
    input  logic [PW-1:0]             rd_phase,
    output logic [NTAP-1:0][CW-1:0]   rd_coefs
);
    localparam int CENTRE = NTAP / 2;

    logic [NPH-1:0][NTAP-1:0][CW-1:0] bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPH; p++)
                for (int t = 0; t < NTAP; t++)
                    bank[p][t] <= (t == CENTRE) ? CW'(1 << NORM_SH) : '0;
        end else if (we && (int'(wr_tap) < NTAP)) begin
            bank[wr_phase][wr_tap] <= wr_data;
        end
    end

    assign rd_coefs = bank[rd_phase];

endmodule

// File: rtl/hscale_fir.sv
module hscale_fir
    import hscale_pkg::*;
#(
    parameter int NTAP = TAPS
) (
    input  logic [NTAP-1:0][PIX_W-1:0]  win,
    input  logic [NTAP-1:0][COEF_W-1:0] coefs,
    output pix_t                        result
);
    localparam int PROD_W = COEF_W + PIX_W + 1;

    logic signed [PROD_W-1:0] prod [NTAP];
    logic signed [SUM_W-1:0]  acc;

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign prod[t] = $signed(coefs[t]) * $signed({1'b0, win[t]});
    end

    always_comb begin
        acc = '0;
        for (int t = 0; t < NTAP; t++)
            acc = acc + SUM_W'(prod[t]);
    end

    assign result = round_clamp(acc);

endmodule

// File: rtl/hscale_top.sv
module hscale_top
    import hscale_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ACC_W-1:0]      cfg_step,
    input  logic [LEN_W-1:0]      cfg_in_len,
    input  logic [LEN_W-1:0]      cfg_out_len,
    input  logic                  line_start,
    input  logic                  coef_we,
    input  logic [PHASE_W+TAP_AW-1:0] coef_addr,
    input  logic [COEF_W-1:0]     coef_data,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PIX_W-1:0]      in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PIX_W-1:0]      out_data,
    output logic                  line_done
);
    localparam int CW = LEN_W + 2;

    state_t                 state;
    cfg_t                   cfg_q;
    logic [ACC_W-1:0]       acc;
    logic signed [CW-1:0]   centre;
    logic signed [CW-1:0]   tgt;
    logic [LEN_W-1:0]       rcvd;
    logic [LEN_W-1:0]       issued;
    win_t                   win;
    coefs_t                 coefs;
    pix_t                   fir_out;
    logic [PHASE_W-1:0]     phase;
    logic                   run, need_out, behind, have_in;
    logic                   self_shift, issue, finish, accept;

    hscale_coef_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (coef_we),
        .wr_phase (coef_addr[PHASE_W+TAP_AW-1:TAP_AW]),
        .wr_tap   (coef_addr[TAP_AW-1:0]),
        .wr_data  (coef_data),
        .rd_phase (phase),
        .rd_coefs (coefs)
    );

    hscale_fir u_fir (
        .win    (win),
        .coefs  (coefs),
        .result (fir_out)
    );

    always_comb begin
        run        = (state == ST_RUN);
        tgt        = $signed({2'b00, acc[ACC_W-1:FRAC_W]});
        phase      = acc[FRAC_W-1 -: PHASE_W];
        need_out   = issued < cfg_q.out_len;
        behind     = centre < tgt;
        have_in    = rcvd < cfg_q.in_len;
        in_ready   = run && (need_out ? (behind && have_in) : have_in);
        accept     = in_ready && in_valid;
        self_shift = run && need_out && behind && !have_in;
        issue      = run && need_out && !behind && (!out_valid || out_ready);
        finish     = run && !need_out && !have_in && !out_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg_q     <= '0;
            acc       <= '0;
            centre    <= '0;
            rcvd      <= '0;
            issued    <= '0;
            win       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            line_done <= 1'b0;
        end else begin
            if (issue) begin
                out_valid <= 1'b1;
                out_data  <= fir_out;
                acc       <= acc + cfg_q.step;
                issued    <= issued + 1'b1;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end

            if (accept) begin
                rcvd <= rcvd + 1'b1;
                if (need_out) begin
                    centre <= centre + 1'b1;
                    if (rcvd == '0)
                        win <= {TAPS{in_data}};
                    else
                        win <= {in_data, win[TAPS-1:1]};
                end
            end else if (self_shift) begin
                centre <= centre + 1'b1;
                win    <= {win[TAPS-1], win[TAPS-1:1]};
            end

            if (state == ST_IDLE && line_start) begin
                state     <= ST_RUN;
                cfg_q     <= '{step: cfg_step, in_len: cfg_in_len, out_len: cfg_out_len};
                acc       <= '0;
                centre    <= -$signed(CW'(3));
                rcvd      <= '0;
                issued    <= '0;
                line_done <= 1'b0;
            end else if (finish) begin
                state     <= ST_IDLE;
                line_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hscale_checker.sv
module hscale_checker
    import hscale_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [PIX_W-1:0]        out_data,
    input logic                    line_done,
    input logic signed [LEN_W+1:0] centre,
    input logic signed [LEN_W+1:0] tgt,
    input logic [LEN_W-1:0]        rcvd,
    input logic [LEN_W-1:0]        in_len
);
    // R1: outputs quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !in_ready && !line_done));

    // R2: window centre never passes the accumulator target
    p_centre_bound_r2: assert property (@(posedge clk) disable iff (rst)
        centre <= tgt);

    // R6: never more inputs taken than the line holds
    p_rcvd_bound_r6: assert property (@(posedge clk) disable iff (rst)
        rcvd <= in_len);

    // R7: held output stays put
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: finished line is silent on both streams
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        line_done |-> (!in_ready && !out_valid));
endmodule

bind hscale_top hscale_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .line_done (line_done),
    .centre    (centre),
    .tgt       (tgt),
    .rcvd      (rcvd),
    .in_len    (cfg_q.in_len)
);

// File: tb/hscale_top_test.sv
module hscale_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_step = '0;
    logic [15:0] cfg_in_len = '0;
    logic [15:0] cfg_out_len = '0;
    logic        line_start = 1'b0;
    logic        coef_we = 1'b0;
    logic [7:0]  coef_addr = '0;
    logic [9:0]  coef_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        line_done;

    int nchk = 0;
    int nerr = 0;
    int cf [32][5];
    int pix [64];
    int cur_in, cur_out, cur_step;
    logic [7:0] lf = 8'h5a;

    always #4 clk = ~clk;

    hscale_top uut (.*);

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(int k);
        longint p;
        int i, ph, s, idx, r;
        p  = longint'(k) * longint'(cur_step);
        i  = int'(p >> 16);
        ph = int'((p >> 11) & 31);
        s  = 0;
        for (int t = 0; t < 5; t++) begin
            idx = i - 2 + t;
            if (idx < 0) idx = 0;
            if (idx > cur_in - 1) idx = cur_in - 1;
            s += cf[ph][t] * pix[idx];
        end
        r = (s + 128) >>> 8;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic wr_coef(int ph, int tap, int val);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_addr = 8'((ph << 3) | tap);
        coef_data = 10'(val);
        @(negedge clk);
        coef_we   = 1'b0;
    endtask

    task automatic run_line(string req, int nin, int nout, int step, int seed,
                            bit thr, bit poke);
        int ip, k, cyc;
        cur_in = nin; cur_out = nout; cur_step = step;
        for (int j = 0; j < nin; j++)
            pix[j] = (j % 7 == 3) ? 255 : ((j % 11 == 5) ? 0 : ((seed * 37 + j * 53) & 255));
        @(negedge clk);
        cfg_step = 32'(step); cfg_in_len = 16'(nin); cfg_out_len = 16'(nout);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk("R8 done cleared by start", int'(line_done), 0);
        ip = 0; k = 0; cyc = 0;
        while (1) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (poke && cyc == 6) begin
                line_start = 1'b1;
                cfg_step = 32'h0008_0000; cfg_in_len = 16'd3; cfg_out_len = 16'd1;
            end else begin
                line_start = 1'b0;
            end
            in_valid  = (ip < nin) && (!thr || lf[0]);
            in_data   = (ip < nin) ? 8'(pix[ip]) : 8'h00;
            out_ready = !thr || lf[3];
            if (line_done) break;
            if (in_valid && in_ready) ip++;
            if (out_valid && out_ready) begin
                if (k >= nout) begin
                    chk({req, " R6 extra output"}, k, nout - 1);
                end else begin
                    chk({req, " R2 R3 R4 sample"}, int'(out_data), model(k));
                end
                k++;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                chk({req, " watchdog"}, cyc, 0);
                break;
            end
        end
        in_valid = 1'b0; out_ready = 1'b0; line_start = 1'b0;
        chk({req, " R6 inputs consumed"}, ip, nin);
        chk({req, " R6 outputs produced"}, k, nout);
        chk({req, " R8 done level"}, int'(line_done), 1);
        chk({req, " R8 quiet when done"}, int'(in_ready | out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 in_ready in reset", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 0);
        chk("R1 done after reset", int'(line_done), 0);

        // R1: default pass-through coefficients
        for (int p = 0; p < 32; p++)
            for (int t = 0; t < 5; t++)
                cf[p][t] = (t == 2) ? 256 : 0;
        run_line("R1 default set", 9, 9, 32'h0000_4000, 2, 1'b0, 1'b0);

        // R5: programmed coefficient sets
        for (int p = 0; p < 32; p++) begin
            cf[p][0] = -p; cf[p][1] = 256 - 8 * p; cf[p][2] = 8 * p;
            cf[p][3] = p / 2; cf[p][4] = -(p / 3);
        end
        cf[31][0] = -512; cf[31][1] = 511; cf[31][2] = 511; cf[31][3] = 300; cf[31][4] = -300;
        cf[0][0] = 0; cf[0][1] = 0; cf[0][2] = 256; cf[0][3] = 0; cf[0][4] = 0;
        for (int p = 0; p < 32; p++)
            for (int t = 0; t < 5; t++)
                wr_coef(p, t, cf[p][t]);
        // R5: tap field 5..7 must not alter any coefficient
        wr_coef(0, 5, 511);
        wr_coef(0, 7, -512);
        wr_coef(17, 6, 123);

        run_line("R5 unity step", 12, 12, 32'h0001_0000, 1, 1'b0, 1'b0);
        run_line("R2 enlarge x4", 10, 40, 32'h0000_4000, 3, 1'b1, 1'b0);
        run_line("R2 reduce /3", 30, 10, 32'h0003_0000, 4, 1'b0, 1'b0);
        run_line("R9 enlarge x10", 6, 60, 32'h0000_1999, 5, 1'b1, 1'b0);
        run_line("R9 reduce /5", 50, 10, 32'h0005_0000, 6, 1'b1, 1'b0);
        run_line("R3 single sample", 1, 4, 32'h0000_5800, 7, 1'b0, 1'b0);
        run_line("R3 edge odd step", 7, 13, 32'h0000_8c00, 8, 1'b1, 1'b0);
        run_line("R8 start ignored", 20, 15, 32'h0001_5555, 9, 1'b1, 1'b1);
        run_line("R6 drain", 24, 3, 32'h0001_8000, 10, 1'b1, 1'b0);
        run_line("R7 backpressure", 16, 31, 32'h0000_7c00, 11, 1'b1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule